// File: doc/BRIEF.md
# Interrupt Fast Context Shadow

This block keeps a single saved copy of three core registers: the working register, the arithmetic status register and the bank select register. It exists so that an interrupt can be entered and left without any software save or restore. When the core takes an interrupt of any priority, it pulses `irq_take`. The block then copies the three live register values into its shadows. When the handler ends with a return that carries the fast option, the block drives the saved values on its restore outputs. In the next cycle it also pulses a restore strobe, and the core loads the three registers from those outputs.

There is exactly one level of shadow, and every interrupt source writes to it. If a high-priority interrupt arrives while a low-priority handler is running, the shadows are overwritten. The later fast return from the low-priority handler then restores the values saved at high-priority entry. The block marks this case. On every capture, the `ctx_lost` output records whether the context it replaced was still waiting for a fast return. Software has no access to the shadows. The only way in is a capture and the only way out is a fast return.

Top module: `ctx_shadow`

## Requirements
- R1: While `rst_n` is low, and after it is released, the shadows, `rs_w`, `rs_status`, `rs_bank`, `rs_stb` and `ctx_lost` are all zero. A fast return before any capture therefore restores zeros.
- R2: When `irq_take` is high at a clock edge, the shadows load the values of `live_w`, `live_status` and `live_bank` present at that edge.
- R3: When `ret_req` and `ret_fast` are high and `irq_take` is low at an edge, `rs_stb` is high for exactly the following cycle. In that cycle, `rs_w`, `rs_status` and `rs_bank` equal the shadow contents from before that edge.
- R4: A return with `ret_req` high and `ret_fast` low is a plain return. It raises no strobe and leaves the shadows unchanged.
- R5: `rs_stb` is low in any cycle that does not follow a fast-return edge. The restore outputs hold their last values while no restore takes place.
- R6: If `irq_take` and a fast return occur at the same edge, the capture wins. No strobe follows, the restore outputs do not change, and the shadows take the new live values.
- R7: A second capture with no fast return in between replaces the shadows, so a later fast return restores the second set of values.
- R8: On each capture, `ctx_lost` becomes 1 if a previous capture has not yet been consumed by a fast return, and becomes 0 otherwise. A fast return marks the context consumed and leaves `ctx_lost` as it is.
- R9: When `irq_take` is low, the shadows ignore any change on the live inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_take | input | 1 | Core is vectoring to an interrupt this cycle |
| live_w | input | W_W | Current working register value |
| live_status | input | ST_W | Current status register value |
| live_bank | input | BK_W | Current bank select value |
| ret_req | input | 1 | Return from interrupt executes this cycle |
| ret_fast | input | 1 | The return carries the fast-restore option |
| rs_w | output | W_W | Working register restore value |
| rs_status | output | ST_W | Status register restore value |
| rs_bank | output | BK_W | Bank select restore value |
| rs_stb | output | 1 | One-cycle pulse: load the restore values |
| ctx_lost | output | 1 | The last capture overwrote an unconsumed context |

## Verification
A capture and a fast restore can fall on the same clock edge. This is what happens when an interrupt is taken in the very cycle that a handler's fast return executes. The bench provokes it by raising `irq_take`, `ret_req` and `ret_fast` together across a sweep of live values. It then checks that no strobe follows and that the restore outputs keep their old values. A later lone fast return must bring back the newly captured values, and `ctx_lost` must reflect the context that the first capture left unconsumed.

// File: rtl/ctx_shadow.sv
module ctx_shadow #(
  parameter int W_W  = 8,
  parameter int ST_W = 5,
  parameter int BK_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_take,
  input  logic [W_W-1:0]  live_w,
  input  logic [ST_W-1:0] live_status,
  input  logic [BK_W-1:0] live_bank,
  input  logic            ret_req,
  input  logic            ret_fast,
  output logic [W_W-1:0]  rs_w,
  output logic [ST_W-1:0] rs_status,
  output logic [BK_W-1:0] rs_bank,
  output logic            rs_stb,
  output logic            ctx_lost
);

  localparam int CTX_W = W_W + ST_W + BK_W;

  logic [CTX_W-1:0] shadow;
  logic [CTX_W-1:0] restore_q;
  logic             armed;
  logic             do_restore;

  assign do_restore = ret_req & ret_fast & ~irq_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      armed  <= 1'b0;
      ctx_lost <= 1'b0;
    end else if (irq_take) begin
      shadow   <= {live_w, live_status, live_bank};
      armed    <= 1'b1;
      ctx_lost <= armed;
    end else if (do_restore) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      restore_q <= '0;
      rs_stb    <= 1'b0;
    end else begin
      rs_stb <= do_restore;
      if (do_restore) restore_q <= shadow;
    end
  end

  assign {rs_w, rs_status, rs_bank} = restore_q;

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> shadow == {$past(live_w), $past(live_status), $past(live_bank)});

  p_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && ret_fast && !irq_take) |=> rs_stb && ({rs_w, rs_status, rs_bank} == $past(shadow)));

  p_plain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !ret_fast) |=> !rs_stb);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ret_req && ret_fast && !irq_take) |=> !rs_stb && $stable({rs_w, rs_status, rs_bank}));

  p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && ret_req && ret_fast) |=> !rs_stb && armed);

  p_lost_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> ctx_lost == $past(armed));

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_take |=> $stable(shadow));

endmodule

// File: tb/sim_ctx_shadow.sv
`timescale 1ns/1ps
module sim_ctx_shadow;
  logic clk = 0, rst_n = 0;
  logic irq_take = 0, ret_req = 0, ret_fast = 0;
  logic [7:0] live_w = 0;
  logic [4:0] live_status = 0;
  logic [3:0] live_bank = 0;
  logic [7:0] rs_w;
  logic [4:0] rs_status;
  logic [3:0] rs_bank;
  logic rs_stb, ctx_lost;

  int total = 0, bad = 0;
  logic [16:0] m_sh, m_rs;
  logic m_stb, m_armed, m_lost;

  always #2.5 clk = ~clk;

  ctx_shadow u0 (.clk(clk), .rst_n(rst_n), .irq_take(irq_take), .live_w(live_w),
    .live_status(live_status), .live_bank(live_bank), .ret_req(ret_req), .ret_fast(ret_fast),
    .rs_w(rs_w), .rs_status(rs_status), .rs_bank(rs_bank), .rs_stb(rs_stb), .ctx_lost(ctx_lost));

  task automatic chk(string tag);
    total++;
    if ({rs_w, rs_status, rs_bank} !== m_rs || rs_stb !== m_stb || ctx_lost !== m_lost) begin
      bad++;
      $display("FAIL %s: got rs=%h stb=%b lost=%b expected rs=%h stb=%b lost=%b",
               tag, {rs_w, rs_status, rs_bank}, rs_stb, ctx_lost, m_rs, m_stb, m_lost);
    end
  endtask

  task automatic step(input logic irq, input logic rr, input logic rf,
                      input logic [16:0] live, input string tag);
    logic dr;
    irq_take = irq; ret_req = rr; ret_fast = rf;
    {live_w, live_status, live_bank} = live;
    dr = rr && rf && !irq;
    @(posedge clk);
    m_stb = dr;
    if (dr) begin m_rs = m_sh; m_armed = 0; end
    if (irq) begin m_lost = m_armed; m_armed = 1; m_sh = live; end
    @(negedge clk);
    irq_take = 0; ret_req = 0; ret_fast = 0;
    chk(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_sh = 0; m_rs = 0; m_stb = 0; m_armed = 0; m_lost = 0;
    repeat (3) @(negedge clk);
    chk("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release");
    step(0, 1, 1, 17'h1ffff, "R1 restore zeros");
    step(0, 0, 0, 17'h0, "R5 strobe drops");

    for (int i = 0; i < 256; i++) begin
      logic [16:0] v;
      v = {8'(i), 5'(i * 7), 4'(i * 3 + 1)};
      step(1, 0, 0, v, "R2 capture");
      step(0, 0, 0, ~v, "R9 live change ignored");
      step(0, 1, 1, 17'h0, "R3 fast return");
      step(0, 0, 0, v ^ 17'h5a5a, "R5 hold after strobe");
    end

    for (int i = 0; i < 64; i++) begin
      logic [16:0] v;
      v = {8'(i * 5), 5'(i), 4'(i)};
      step(1, 0, 0, v, "R2 capture");
      step(0, 1, 0, ~v, "R4 plain return");
      step(0, 1, 0, 17'h0, "R4 second plain return");
      step(0, 1, 1, 17'h0, "R4 fast after plain");
    end

    for (int i = 0; i < 128; i++) begin
      logic [16:0] a, b;
      a = {8'(i), 5'(i + 3), 4'(i + 9)};
      b = {8'(255 - i), 5'(i * 11), 4'(i * 5)};
      step(1, 0, 0, a, "R2 capture");
      step(1, 1, 1, b, "R6 capture beats restore");
      step(0, 1, 1, 17'h0, "R6 later restore gives new values");
    end

    for (int i = 0; i < 64; i++) begin
      logic [16:0] lo, hi;
      lo = {8'(i * 3), 5'(i), 4'(i)};
      hi = {8'(i * 9 + 1), 5'(31 - i), 4'(15 - i)};
      step(1, 0, 0, lo, "R8 fresh capture");
      step(1, 0, 0, hi, "R8 nested capture sets lost");
      step(0, 1, 1, 17'h0, "R7 inner return restores inner");
      step(0, 1, 1, 17'h0, "R7 outer return restores inner values");
      step(1, 0, 0, lo, "R8 capture after consume clears lost");
      step(0, 1, 1, 17'h0, "R3 restore");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule